// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a multicycle processor that runs a small integer subset: register-type ALU operations, load word, store word, branch-if-equal and jump. A microprogram counter selects one word from a ten-word microcode store. That word drives every datapath control line and carries a 2-bit sequencing code. The code picks the next microaddress from one of four sources: the counter plus one, a return to fetch, or one of two opcode lookup tables.

The datapath sets the 6-bit opcode from its instruction register. While `step_en` is high, the sequencer moves one microinstruction per clock. While `step_en` is low, it holds its state, so an environment can stall it or single-step it. The current microaddress is an output so that the address trace of each instruction class can be observed.

Top module: `ucode_seq`

## Requirements
- R1: A synchronous reset puts the microaddress at 0 on the next edge, whatever `step_en` is, and the fetch controls of R3 appear.
- R2: While `step_en` is low and reset is low, the microaddress and all control outputs keep their values.
- R3: The control vector {alu_op[1:0], src_a, src_b[1:0], reg_write, reg_dst, mem_to_reg, mem_read, mem_write, ir_write, addr_sel, pc_src[1:0], pc_write, pc_write_cond} has the following value at each microaddress. Fields that are not named are 0. alu_op codes: 00 add, 01 subtract, 10 function code. src_b codes: 00 B, 01 constant 4, 10 immediate, 11 shifted immediate.
  - 0: add, src_b=01, mem_read, ir_write, pc_write.
  - 1: add, src_b=11.
  - 2: add, src_a=1, src_b=10.
  - 3: mem_read, addr_sel.
  - 4: reg_write, mem_to_reg.
  - 5: mem_write, addr_sel.
  - 6: alu_op=10, src_a=1.
  - 7: reg_write, reg_dst.
  - 8: alu_op=01, src_a=1, pc_src=01, pc_write_cond.
  - 9: pc_src=10, pc_write.
- R4: From address 1, the first table maps opcode 000000 to 6, 000010 to 9, 000100 to 8, and both 100011 and 101011 to 2.
- R5: From address 2, the second table maps 100011 to 3 and 101011 to 5.
- R6: A load word (100011) walks the trace 0,1,2,3,4,0.
- R7: A store word (101011) walks the trace 0,1,2,5,0.
- R8: A register-type operation (000000) walks the trace 0,1,6,7,0.
- R9: A branch (000100) walks 0,1,8,0, and a jump (000010) walks 0,1,9,0.
- R10: An opcode missing from the table in use sends the sequencer to address 0. This applies at either dispatch point.
- R11: mem_read and mem_write are never high together, and reg_write is high only at addresses 4 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the microprogram counter |
| opcode | input | 6 | Opcode field of the instruction register |
| uaddr | output | 4 | Current microaddress |
| alu_op | output | 2 | ALU operation class |
| src_a | output | 1 | Top ALU input: 0 PC, 1 A |
| src_b | output | 2 | Bottom ALU input select |
| reg_write | output | 1 | Register file write |
| reg_dst | output | 1 | Write to rd (1) or rt (0) |
| mem_to_reg | output | 1 | Write data from MDR |
| mem_read | output | 1 | Memory read |
| mem_write | output | 1 | Memory write |
| ir_write | output | 1 | Load instruction register |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALUOut |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALUOut, 10 jump target |
| pc_write | output | 1 | Unconditional PC write |
| pc_write_cond | output | 1 | PC write if ALU zero |

## Verification
Reset and a step request can arrive in the same cycle. The bench drives both high partway through a load, when the sequencer sits at address 3 and would otherwise move to 4, and it requires address 0 with fetch controls on the next edge. The bench also changes the opcode between the two dispatch points. This makes the second table miss in the same cycle that it is consulted, and the bench judges the result by a return to address 0 instead of address 3 or 5.

// File: rtl/ucode_seq.sv
module ucode_seq #(
  parameter int UA_W = 4,
  parameter int OP_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_en,
  input  logic [OP_W-1:0] opcode,
  output logic [UA_W-1:0] uaddr,
  output logic [1:0]      alu_op,
  output logic            src_a,
  output logic [1:0]      src_b,
  output logic            reg_write,
  output logic            reg_dst,
  output logic            mem_to_reg,
  output logic            mem_read,
  output logic            mem_write,
  output logic            ir_write,
  output logic            addr_sel,
  output logic [1:0]      pc_src,
  output logic            pc_write,
  output logic            pc_write_cond
);
  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_JMP   = 6'b000010;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_LW    = 6'b100011;
  localparam logic [OP_W-1:0] OP_SW    = 6'b101011;

  localparam logic [1:0] SQ_FETCH = 2'b00;
  localparam logic [1:0] SQ_TBL1  = 2'b01;
  localparam logic [1:0] SQ_TBL2  = 2'b10;

  logic [15:0]     ctl;
  logic [1:0]      seq;
  logic [UA_W-1:0] tbl1, tbl2, nxt;

  always_comb begin
    case (uaddr)
      UA_W'(0): {ctl, seq} = {16'b00_0_01_000_1010_00_10, 2'b11};
      UA_W'(1): {ctl, seq} = {16'b00_0_11_000_0000_00_00, SQ_TBL1};
      UA_W'(2): {ctl, seq} = {16'b00_1_10_000_0000_00_00, SQ_TBL2};
      UA_W'(3): {ctl, seq} = {16'b00_0_00_000_1001_00_00, 2'b11};
      UA_W'(4): {ctl, seq} = {16'b00_0_00_101_0000_00_00, SQ_FETCH};
      UA_W'(5): {ctl, seq} = {16'b00_0_00_000_0101_00_00, SQ_FETCH};
      UA_W'(6): {ctl, seq} = {16'b10_1_00_000_0000_00_00, 2'b11};
      UA_W'(7): {ctl, seq} = {16'b00_0_00_110_0000_00_00, SQ_FETCH};
      UA_W'(8): {ctl, seq} = {16'b01_1_00_000_0000_01_01, SQ_FETCH};
      UA_W'(9): {ctl, seq} = {16'b00_0_00_000_0000_10_10, SQ_FETCH};
      default:  {ctl, seq} = {16'b0, SQ_FETCH};
    endcase
  end

  assign {alu_op, src_a, src_b, reg_write, reg_dst, mem_to_reg,
          mem_read, mem_write, ir_write, addr_sel, pc_src,
          pc_write, pc_write_cond} = ctl;

  always_comb begin
    case (opcode)
      OP_RTYPE:     tbl1 = UA_W'(6);
      OP_JMP:       tbl1 = UA_W'(9);
      OP_BEQ:       tbl1 = UA_W'(8);
      OP_LW, OP_SW: tbl1 = UA_W'(2);
      default:      tbl1 = '0;
    endcase
    case (opcode)
      OP_LW:   tbl2 = UA_W'(3);
      OP_SW:   tbl2 = UA_W'(5);
      default: tbl2 = '0;
    endcase
    case (seq)
      SQ_FETCH: nxt = '0;
      SQ_TBL1:  nxt = tbl1;
      SQ_TBL2:  nxt = tbl2;
      default:  nxt = uaddr + UA_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          uaddr <= '0;
    else if (step_en) uaddr <= nxt;
  end
endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       step_en,
  input logic [5:0] opcode,
  input logic [3:0] uaddr,
  input logic       reg_write,
  input logic       mem_read,
  input logic       mem_write,
  input logic       ir_write,
  input logic       pc_write
);
  p_reset_r1: assert property (@(posedge clk) rst |=> uaddr == 4'd0);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(uaddr));

  p_fetch_r3: assert property (@(posedge clk) disable iff (rst)
    uaddr == 4'd0 |-> (mem_read && ir_write && pc_write));

  p_ld_step_r6: assert property (@(posedge clk) disable iff (rst)
    (step_en && uaddr == 4'd3) |=> uaddr == 4'd4);

  p_miss_r10: assert property (@(posedge clk) disable iff (rst)
    (step_en && uaddr == 4'd1 && opcode != 6'b000000 && opcode != 6'b000010 &&
     opcode != 6'b000100 && opcode != 6'b100011 && opcode != 6'b101011)
    |=> uaddr == 4'd0);

  p_mem_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_read && mem_write));

  p_rw_site_r11: assert property (@(posedge clk) disable iff (rst)
    reg_write |-> (uaddr == 4'd4 || uaddr == 4'd7));
endmodule

bind ucode_seq ucode_seq_chk u_chk (
  .clk(clk), .rst(rst), .step_en(step_en), .opcode(opcode), .uaddr(uaddr),
  .reg_write(reg_write), .mem_read(mem_read), .mem_write(mem_write),
  .ir_write(ir_write), .pc_write(pc_write)
);

// File: tb/ucode_seq_bench.sv
module ucode_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b1;
  logic [5:0] opcode = 6'b0;
  logic [3:0] uaddr;
  logic [1:0] alu_op, src_b, pc_src;
  logic       src_a, reg_write, reg_dst, mem_to_reg, mem_read, mem_write;
  logic       ir_write, addr_sel, pc_write, pc_write_cond;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ucode_seq u_ucode_seq (
    .clk(clk), .rst(rst), .step_en(step_en), .opcode(opcode), .uaddr(uaddr),
    .alu_op(alu_op), .src_a(src_a), .src_b(src_b), .reg_write(reg_write),
    .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .mem_read(mem_read),
    .mem_write(mem_write), .ir_write(ir_write), .addr_sel(addr_sel),
    .pc_src(pc_src), .pc_write(pc_write), .pc_write_cond(pc_write_cond)
  );

  wire [15:0] ctl = {alu_op, src_a, src_b, reg_write, reg_dst, mem_to_reg,
                     mem_read, mem_write, ir_write, addr_sel, pc_src,
                     pc_write, pc_write_cond};

  function automatic logic [15:0] exp_ctl(input int a);
    case (a)
      0: return 16'b00_0_01_000_1010_00_10;
      1: return 16'b00_0_11_000_0000_00_00;
      2: return 16'b00_1_10_000_0000_00_00;
      3: return 16'b00_0_00_000_1001_00_00;
      4: return 16'b00_0_00_101_0000_00_00;
      5: return 16'b00_0_00_000_0101_00_00;
      6: return 16'b10_1_00_000_0000_00_00;
      7: return 16'b00_0_00_110_0000_00_00;
      8: return 16'b01_1_00_000_0000_01_01;
      9: return 16'b00_0_00_000_0000_10_10;
      default: return 16'b0;
    endcase
  endfunction

  task automatic adv();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_at(input string req, input int a);
    checks++;
    if (uaddr !== 4'(a)) begin
      errors++;
      $display("FAIL %s uaddr act=%0d exp=%0d", req, uaddr, a);
    end
    checks++;
    if (ctl !== exp_ctl(a)) begin
      errors++;
      $display("FAIL R3/%s ctl at %0d act=%b exp=%b", req, a, ctl, exp_ctl(a));
    end
  endtask

  task automatic walk(input string req, input logic [5:0] op, input int t0,
                      input int t1, input int t2, input int t3, input int n);
    int tr[4];
    tr = '{t0, t1, t2, t3};
    opcode = op;
    expect_at(req, 0);
    for (int i = 0; i < n; i++) begin
      adv();
      expect_at(req, tr[i]);
    end
  endtask

  task automatic test_reset();
    rst = 1'b1; step_en = 1'b1;
    adv(); adv();
    expect_at("R1", 0);
    rst = 1'b0;
  endtask

  task automatic test_hold();
    opcode = 6'b100011;
    adv(); expect_at("R2", 1);
    step_en = 1'b0;
    adv(); expect_at("R2", 1);
    adv(); expect_at("R2", 1);
    step_en = 1'b1;
    adv(); expect_at("R4", 2);
    adv(); expect_at("R5", 3);
    adv(); adv(); expect_at("R2", 0);
  endtask

  task automatic test_reset_mid();
    opcode = 6'b100011;
    adv(); adv(); adv();
    expect_at("R1", 3);
    rst = 1'b1;
    adv(); expect_at("R1", 0);
    rst = 1'b0;
  endtask

  task automatic test_tbl2_miss();
    opcode = 6'b101011;
    adv(); adv(); expect_at("R10", 2);
    opcode = 6'b000000;
    adv(); expect_at("R10", 0);
  endtask

  task automatic test_tbl1_miss();
    walk("R10", 6'b111111, 1, 0, 0, 0, 2);
    walk("R10", 6'b100010, 1, 0, 0, 0, 2);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    test_reset();
    walk("R6", 6'b100011, 1, 2, 3, 4, 4); adv(); expect_at("R6", 0);
    walk("R7", 6'b101011, 1, 2, 5, 0, 4);
    walk("R8", 6'b000000, 1, 6, 7, 0, 4);
    walk("R9", 6'b000100, 1, 8, 0, 0, 3);
    walk("R9", 6'b000010, 1, 9, 0, 0, 3);
    test_hold();
    test_reset_mid();
    test_tbl2_miss();
    test_tbl1_miss();
    finish_run();
  end
endmodule